// File: doc/BRIEF.md
# Qualified Power-On Reset Sequencer

This block holds a chip in reset until three conditions are all true together: the supply is good, the oscillator is running, and the external active-low reset pin is high. When all three have stayed true for a set number of clock cycles, the block releases the internal reset. It also releases the tri-state hold on the parallel data and memory interface pins. While any condition is false, reset is held. This lets another master share the memory bus during reset.

The block also sets how the active-low reset output pin is driven. The external reset pin pulled low forces that output to drive low. During the qualification delay the output floats (high-impedance). After release it drives high. The two drive enables are never both active. A USB bus reset pulse reaches the block but has no effect on any output.

If any condition drops, reset asserts at once without waiting for a clock edge. The delay counter clears, so the full delay starts again when the conditions return. The delay is `DELAY` cycles, for example 60000 cycles at 12 MHz for about 5 ms. Release is synchronous through a `SYNC_STAGES`-deep synchronizer.

Top module: `por_sequencer`

## Requirements
- R1: Once supply_ok, osc_run and ext_rst_n are all 1, core_rst falls exactly DELAY+SYNC_STAGES rising clock edges later, counting the first edge after the last condition went true. It stays 1 before that edge.
- R2: While core_rst is 1 and ext_rst_n is 1, both rstout_lo_en and rstout_hi_en are 0 (output high-impedance). While core_rst is 0, rstout_hi_en is 1.
- R3: While ext_rst_n is 0, rstout_lo_en is 1 and rstout_hi_en is 0, with no clock edge needed.
- R4: When any of the three conditions goes false, core_rst becomes 1 without a clock edge. When the conditions return, the full delay of R1 is counted again from zero.
- R5: rstout_lo_en and rstout_hi_en are never 1 at the same time.
- R6: pins_tz is 1 exactly when core_rst is 1.
- R7: bus_rst has no effect on core_rst, pins_tz, rstout_lo_en or rstout_hi_en, whether it arrives during the delay or after release.
- R8: Out of power-up with the conditions false, core_rst and pins_tz are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| supply_ok | input | 1 | Supply above threshold (1 = good) |
| osc_run | input | 1 | Oscillator running (1 = running) |
| ext_rst_n | input | 1 | External reset pin, active low |
| bus_rst | input | 1 | USB bus reset pulse, ignored |
| core_rst | output | 1 | Internal reset, active high |
| rstout_lo_en | output | 1 | Drive the reset output pin low |
| rstout_hi_en | output | 1 | Drive the reset output pin high |
| pins_tz | output | 1 | Tri-state the interface and memory pins |

## Verification
The checker's window counter assumes that the qualifying inputs change only between clock edges and that a dropped condition is visible before the next edge. The bench therefore moves every input one nanosecond after a rising edge, and it samples the outputs just before the next change. The checker treats the AND of the three conditions as the block's only reset. Its clocked properties are disabled while that AND is false, and the purely combinational relations are checked at the falling edge. The stimulus aborts the delay after every possible count, once for each condition. It pulses bus_rst both inside the delay and after release.

// File: rtl/por_pkg.sv
package por_pkg;
   typedef enum logic [1:0] {
      PIN_FLOAT = 2'b00,
      PIN_LOW   = 2'b01,
      PIN_HIGH  = 2'b10
   } pin_mode_e;
endpackage

// File: rtl/por_cond_sync.sv
module por_cond_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic cond_ok,
   output logic sync_ok
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("por_cond_sync: STAGES must be at least 2");
      end
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge cond_ok) begin
            if (!cond_ok) chain[g] <= 1'b0;
            else if (g == 0) chain[g] <= 1'b1;
            else chain[g] <= chain[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign sync_ok = chain[STAGES-1];
endmodule

// File: rtl/por_hold_timer.sv
module por_hold_timer #(
   parameter int DELAY = 60000
) (
   input  logic clk,
   input  logic arst_n,
   input  logic go,
   output logic done
);
   localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
   localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

   logic [CW-1:0] cnt;

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("por_hold_timer: DELAY must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (go && !done) begin
         if (cnt == LAST) done <= 1'b1;
         else cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/por_out_stage.sv
module por_out_stage
   import por_pkg::*;
(
   input  logic ext_rst_n,
   input  logic released,
   output logic core_rst,
   output logic pins_tz,
   output logic drive_lo,
   output logic drive_hi
);
   pin_mode_e mode;

   always_comb begin
      if (!ext_rst_n) mode = PIN_LOW;
      else if (!released) mode = PIN_FLOAT;
      else mode = PIN_HIGH;
   end

   assign drive_lo = (mode == PIN_LOW);
   assign drive_hi = (mode == PIN_HIGH);
   assign core_rst = !released;
   assign pins_tz  = !released;
endmodule

// File: rtl/por_sequencer.sv
module por_sequencer #(
   parameter int DELAY       = 60000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic supply_ok,
   input  logic osc_run,
   input  logic ext_rst_n,
   input  logic bus_rst,
   output logic core_rst,
   output logic rstout_lo_en,
   output logic rstout_hi_en,
   output logic pins_tz
);
   logic all_ok;
   logic sync_ok;
   logic released;

   assign all_ok = supply_ok & osc_run & ext_rst_n;

   por_cond_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .cond_ok (all_ok),
      .sync_ok (sync_ok)
   );

   por_hold_timer #(.DELAY(DELAY)) u_timer (
      .clk    (clk),
      .arst_n (all_ok),
      .go     (sync_ok),
      .done   (released)
   );

   por_out_stage u_out (
      .ext_rst_n (ext_rst_n),
      .released  (released),
      .core_rst  (core_rst),
      .pins_tz   (pins_tz),
      .drive_lo  (rstout_lo_en),
      .drive_hi  (rstout_hi_en)
   );
endmodule

// File: rtl/por_sequencer_chk.sv
module por_sequencer_chk #(
   parameter int DELAY       = 60000,
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic supply_ok,
   input logic osc_run,
   input logic ext_rst_n,
   input logic bus_rst,
   input logic core_rst,
   input logic rstout_lo_en,
   input logic rstout_hi_en,
   input logic pins_tz
);
   localparam int LAT = DELAY + SYNC_STAGES;
   localparam int WW  = $clog2(LAT + 1);

   logic q;
   logic [WW-1:0] win;
   assign q = supply_ok & osc_run & ext_rst_n;

   always_ff @(posedge clk or negedge q) begin
      if (!q) win <= '0;
      else if (win != WW'(LAT)) win <= win + 1'b1;
   end

   always @(negedge clk) begin
      AST_EXT_FORCES_LOW: assert (ext_rst_n || (rstout_lo_en && !rstout_hi_en)); // R3
      AST_NO_CONTENTION: assert (!(rstout_lo_en && rstout_hi_en)); // R5
      AST_DROP_RESETS: assert (q || core_rst); // R4
      AST_TZ_FOLLOWS: assert (pins_tz == core_rst); // R6
      AST_FLOAT_IN_DELAY: assert (!(core_rst && ext_rst_n) || (!rstout_lo_en && !rstout_hi_en)); // R2
      AST_HIGH_AFTER: assert (core_rst || rstout_hi_en); // R2
   end

   AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!q)
      (win < WW'(LAT)) |-> core_rst); // R1
   AST_RELEASE_DUE: assert property (@(posedge clk) disable iff (!q)
      (win == WW'(LAT)) |-> !core_rst); // R1
   AST_BUS_IGNORED: assert property (@(posedge clk) disable iff (!q)
      (bus_rst && !core_rst) |=> !core_rst); // R7
endmodule

bind por_sequencer por_sequencer_chk #(.DELAY(DELAY), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk          (clk),
   .supply_ok    (supply_ok),
   .osc_run      (osc_run),
   .ext_rst_n    (ext_rst_n),
   .bus_rst      (bus_rst),
   .core_rst     (core_rst),
   .rstout_lo_en (rstout_lo_en),
   .rstout_hi_en (rstout_hi_en),
   .pins_tz      (pins_tz)
);

// File: tb/por_sequencer_test.sv
module por_sequencer_test;
   localparam int DELAY = 5;
   localparam int SYNC  = 2;
   localparam int LAT   = DELAY + SYNC;

   logic clk = 1'b0;
   logic supply_ok = 1'b0, osc_run = 1'b0, ext_rst_n = 1'b1, bus_rst = 1'b0;
   logic core_rst, rstout_lo_en, rstout_hi_en, pins_tz;
   int vectors = 0, errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   por_sequencer #(.DELAY(DELAY), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .supply_ok(supply_ok), .osc_run(osc_run), .ext_rst_n(ext_rst_n),
      .bus_rst(bus_rst), .core_rst(core_rst), .rstout_lo_en(rstout_lo_en),
      .rstout_hi_en(rstout_hi_en), .pins_tz(pins_tz)
   );

   task automatic chk(string tag, string what, logic act, logic exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // expected outputs derived from the requirements
   task automatic check_all(string tag, bit exp_rst);
      chk(tag, "core_rst", core_rst, exp_rst);
      chk(tag, "pins_tz (R6)", pins_tz, exp_rst);
      chk(tag, "lo_en (R3/R5)", rstout_lo_en, !ext_rst_n);
      chk(tag, "hi_en (R2/R5)", rstout_hi_en, ext_rst_n && !exp_rst);
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic set_cond(int which, logic v);
      case (which)
         0: supply_ok = v;
         1: osc_run = v;
         default: ext_rst_n = v;
      endcase
   endtask

   // with all conditions just raised, walk the delay and check the release edge
   task automatic walk_release(string tag);
      for (int i = 1; i < LAT; i++) begin
         tick();
         check_all(tag, 1'b1);
      end
      tick();
      check_all(tag, 1'b0);
   endtask

   initial begin
      #1;
      check_all("R8", 1'b1);
      tick();
      check_all("R8", 1'b1);
      // R3: external low while other conditions false
      ext_rst_n = 1'b0; #1;
      check_all("R3", 1'b1);
      ext_rst_n = 1'b1;
      tick();
      supply_ok = 1'b1; osc_run = 1'b1;
      walk_release("R1");
      // R1 long hold stays released
      for (int i = 0; i < 10; i++) begin
         tick();
         check_all("R1", 1'b0);
      end
      // R4 sweep: each condition dropped after every possible count
      for (int which = 0; which < 3; which++) begin
         for (int k = 0; k <= LAT + 1; k++) begin
            set_cond(which, 1'b0); #1;
            check_all("R4", 1'b1);
            tick();
            set_cond(which, 1'b1);
            for (int j = 0; j < k; j++) begin
               tick();
               check_all("R4", j + 1 >= LAT ? 1'b0 : 1'b1);
            end
            set_cond(which, 1'b0); #1;
            check_all("R4", 1'b1);
            tick();
            set_cond(which, 1'b1);
            walk_release("R4");
         end
      end
      // R7: bus reset during delay and after release
      supply_ok = 1'b0; #1;
      tick();
      supply_ok = 1'b1;
      for (int i = 1; i < LAT; i++) begin
         bus_rst = (i % 2 == 1);
         tick();
         check_all("R7", 1'b1);
      end
      bus_rst = 1'b0;
      tick();
      check_all("R7", 1'b0);
      for (int i = 0; i < 6; i++) begin
         bus_rst = 1'b1;
         tick();
         check_all("R7", 1'b0);
         bus_rst = 1'b0;
         tick();
         check_all("R7", 1'b0);
      end
      // R3 after release: external low drives the pin low immediately
      ext_rst_n = 1'b0; #1;
      check_all("R3", 1'b1);
      tick();
      check_all("R3", 1'b1);
      ext_rst_n = 1'b1;
      walk_release("R1");
      if (!finished) begin
         finished = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!finished) begin
         finished = 1;
         errors++;
         vectors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule